// File: doc/BRIEF.md
# Sleep and Wake-Up Sequencer

This block sequences power-down for a small 8-bit processor core. When the decoder raises a one-cycle sleep strobe, the block does three things. It turns off the oscillator enable, halts the core and asks the watchdog to reset its count. It also records entry into sleep in two status bits: a power-down flag and a time-out flag. It then waits for a wake source. A watchdog time-out wakes the core only when the watchdog is enabled. An interrupt wakes it when that interrupt's flag and its own enable are both set. The external reset always restarts everything.

After a wake, the oscillator is switched back on and the core stays halted for a fixed start-up count of oscillator edges. The core is then released on the first phase of an instruction cycle. On release, the prefetched instruction after the sleep strobe always executes first. If the wake came from an interrupt and the global interrupt enable is set at release time, a one-cycle vector pulse with the target address 0x0004 follows one instruction cycle later. If an enabled interrupt is already pending when the sleep strobe arrives, the sleep still completes but the oscillator never stops and the start-up count is skipped.

States: RUN (core running), SLEEP (oscillator off), START (start-up count), ALIGN (wait for phase boundary), RESUME (release cycle), PREVEC (instruction after sleep executes), VECTOR (vector pulse). Transitions: RUN→SLEEP on strobe with nothing pending; RUN→ALIGN on strobe with an enabled interrupt pending; SLEEP→START on a watchdog wake or interrupt wake; START→ALIGN when the count is done; ALIGN→RESUME at the last phase; RESUME→PREVEC for an interrupt wake with global enable set, RESUME→RUN otherwise; PREVEC→VECTOR at the last phase; VECTOR→RUN.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While and after the external reset, status_pd=1, status_to=1, osc_en=1, core_halt=0, cyc_phase=0, and wdt_clear, resume_pulse and vector_pulse are 0.
- R2: A sleep strobe in RUN gives status_pd=0 and status_to=1 at the next edge, with wdt_clear high for exactly the one following cycle.
- R3: While asleep, osc_en=0 and core_halt=1. The following are ignored: an interrupt flag whose enable is 0, a watchdog time-out with wdt_enable=0, and the global enable alone.
- R4: Any interrupt source with irq_flag[i]=1 and irq_en[i]=1 wakes the core from sleep whatever gie is, and status_to stays 1.
- R5: A watchdog time-out with wdt_enable=1 wakes the core and clears status_to to 0. The core resumes in line even with gie=1. If it arrives in the same cycle as an interrupt wake, the watchdog is taken as the cause.
- R6: Every wake out of sleep raises wdt_clear for exactly the first cycle after the wake edge.
- R7: After a wake from sleep, osc_en=1 and core_halt=1 hold for OST_CYCLES cycles. Further halted cycles follow until cyc_phase reaches PHASES-1, and the release cycle has cyc_phase=0. cyc_phase advances by one (mod PHASES) at every edge where osc_en was 1, and holds while asleep.
- R8: The release cycle has resume_pulse=1 for one cycle and core_halt=0.
- R9: For an interrupt wake with gie=1 at release, vector_pulse is high for one cycle, exactly PHASES cycles after resume_pulse. vector_addr=0x0004. With gie=0, no vector pulse occurs.
- R10: A sleep strobe while an enabled interrupt is pending sets status_pd=0 and status_to=1 and pulses wdt_clear. osc_en stays 1 and no start-up count runs: release comes on the next phase boundary, and R9 applies.
- R11: The external reset asserted during sleep brings every output to its R1 value at once.
- R12: A watchdog time-out while running changes neither the status bits nor core_halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | External active-low reset, also power-up |
| sleep_req | input | 1 | Decoded sleep strobe, one cycle |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| wdt_enable | input | 1 | Watchdog enabled |
| irq_flag | input | IRQ_N | Interrupt flags |
| irq_en | input | IRQ_N | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| osc_en | output | 1 | Oscillator driver enable |
| core_halt | output | 1 | Holds the core |
| wdt_clear | output | 1 | Watchdog count clear |
| resume_pulse | output | 1 | Core released, continue with prefetched instruction |
| vector_pulse | output | 1 | Branch to interrupt vector |
| vector_addr | output | 16 | Vector target address |
| cyc_phase | output | 2 | Oscillator phase within instruction cycle |
| status_to | output | 1 | Time-out status bit |
| status_pd | output | 1 | Power-down status bit |

## Verification
The bench walks every interrupt source and the watchdog, with the global enable both set and clear, and varies the idle gap between cases so that wakes start from every phase. An alignment error would release the core mid-cycle or one cycle off the exact count. The pending-at-strobe case catches a design that shuts the oscillator off or runs a needless start-up count. Simultaneous watchdog and interrupt wakes catch a wrong priority that leaves status_to set or vectors. Time-outs with the watchdog disabled and flags without enables catch false wakes, and a reset mid-sleep catches status bits that are not restored.

// File: rtl/swc_pkg.sv
package swc_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_SLEEP,
        ST_START,
        ST_ALIGN,
        ST_RESUME,
        ST_PREVEC,
        ST_VECTOR
    } swc_state_e;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_IRQ,
        WK_WDT
    } wake_src_e;
endpackage

// File: rtl/swc_phase.sv
module swc_phase #(
    parameter int PHASES = 4,
    localparam int PH_W = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    localparam logic [PH_W-1:0] PH_MAX = PH_W'(PHASES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (en) begin
            phase <= (phase == PH_MAX) ? '0 : phase + 1'b1;
        end
    end

    assign last = (phase == PH_MAX);

    // R7: phase frozen while the oscillator is off
    p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(phase));
endmodule

// File: rtl/swc_ost.sv
module swc_ost #(
    parameter int CYCLES = 1024,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != CNT_LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == CNT_LAST);

    // R7: counter never runs past the start-up length
    p_ost_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);
    // R7: count restarts from zero each time the start-up window opens
    p_ost_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/swc_status.sv
module swc_status (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_exec,
    input  logic wdt_wake,
    output logic pd,
    output logic to
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd <= 1'b1;
            to <= 1'b1;
        end else if (sleep_exec) begin
            pd <= 1'b0;
            to <= 1'b1;
        end else if (wdt_wake) begin
            to <= 1'b0;
        end
    end

    // R2: sleep entry clears power-down and sets time-out
    p_pd_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_exec |=> (!pd && to));
    // R5: watchdog wake clears time-out
    p_to_wdt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_wake |=> !to);
    // R12: status only moves on sleep entry or watchdog wake
    p_status_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_exec && !wdt_wake) |=> ($stable(pd) && $stable(to)));
endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
    import swc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wdt_hit,
    input  logic       irq_pend,
    input  logic       gie,
    input  logic       phase_last,
    input  logic       ost_done,
    output swc_state_e state,
    output logic       osc_en,
    output logic       core_halt,
    output logic       resume,
    output logic       vec,
    output logic       wdt_clr,
    output logic       sleep_exec,
    output logic       wdt_wake
);
    swc_state_e state_nxt;
    wake_src_e  src_q, src_nxt;
    logic       wake_now;

    assign sleep_exec = (state == ST_RUN) && sleep_req;
    assign wdt_wake   = (state == ST_SLEEP) && wdt_hit;
    assign wake_now   = (state == ST_SLEEP) && (wdt_hit || irq_pend);

    // next-state and wake cause
    always_comb begin
        state_nxt = state;
        src_nxt   = src_q;
        unique case (state)
            ST_RUN: begin
                if (sleep_req) begin
                    if (irq_pend) begin
                        state_nxt = ST_ALIGN;
                        src_nxt   = WK_IRQ;
                    end else begin
                        state_nxt = ST_SLEEP;
                        src_nxt   = WK_NONE;
                    end
                end
            end
            ST_SLEEP: begin
                if (wdt_hit) begin
                    state_nxt = ST_START;
                    src_nxt   = WK_WDT;
                end else if (irq_pend) begin
                    state_nxt = ST_START;
                    src_nxt   = WK_IRQ;
                end
            end
            ST_START: begin
                if (ost_done) state_nxt = ST_ALIGN;
            end
            ST_ALIGN: begin
                if (phase_last) state_nxt = ST_RESUME;
            end
            ST_RESUME: begin
                if (src_q == WK_IRQ && gie) state_nxt = ST_PREVEC;
                else                        state_nxt = ST_RUN;
            end
            ST_PREVEC: begin
                if (phase_last) state_nxt = ST_VECTOR;
            end
            ST_VECTOR: begin
                state_nxt = ST_RUN;
                src_nxt   = WK_NONE;
            end
            default: begin
                state_nxt = ST_RUN;
                src_nxt   = WK_NONE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_RUN;
            src_q   <= WK_NONE;
            wdt_clr <= 1'b0;
        end else begin
            state   <= state_nxt;
            src_q   <= src_nxt;
            wdt_clr <= sleep_exec || wake_now;
        end
    end

    // outputs
    always_comb begin
        osc_en    = 1'b1;
        core_halt = 1'b0;
        resume    = 1'b0;
        vec       = 1'b0;
        unique case (state)
            ST_RUN:    ;
            ST_SLEEP:  begin osc_en = 1'b0; core_halt = 1'b1; end
            ST_START:  core_halt = 1'b1;
            ST_ALIGN:  core_halt = 1'b1;
            ST_RESUME: resume = 1'b1;
            ST_PREVEC: ;
            ST_VECTOR: vec = 1'b1;
            default:   ;
        endcase
    end

    // R3: no wake source keeps the core asleep
    p_stay_asleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !wdt_hit && !irq_pend) |=> state == ST_SLEEP);
    // R4: an enabled pending interrupt always wakes
    p_irq_wakes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && irq_pend) |=> state == ST_START);
    // R6: watchdog cleared after every wake
    p_wdt_clr_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_now |=> wdt_clr);
    // R10: pending interrupt at the strobe keeps the oscillator running
    p_immediate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_exec && irq_pend) |=> (osc_en && state == ST_ALIGN));
    // R5: watchdog wake never vectors
    p_wdt_inline_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_wake |=> src_q == WK_WDT);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import swc_pkg::*;
#(
    parameter int          IRQ_N      = 3,
    parameter int          OST_CYCLES = 1024,
    parameter int          PHASES     = 4,
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] VEC_ADDR   = 16'h0004
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sleep_req,
    input  logic                       wdt_timeout,
    input  logic                       wdt_enable,
    input  logic [IRQ_N-1:0]           irq_flag,
    input  logic [IRQ_N-1:0]           irq_en,
    input  logic                       gie,
    output logic                       osc_en,
    output logic                       core_halt,
    output logic                       wdt_clear,
    output logic                       resume_pulse,
    output logic                       vector_pulse,
    output logic [ADDR_W-1:0]          vector_addr,
    output logic [$clog2(PHASES)-1:0]  cyc_phase,
    output logic                       status_to,
    output logic                       status_pd
);
    localparam int PH_W = $clog2(PHASES);

    swc_state_e       state;
    logic [IRQ_N-1:0] armed;
    logic             irq_pend;
    logic             wdt_hit;
    logic             phase_last;
    logic             ost_done;
    logic             ost_run;
    logic             sleep_exec;
    logic             wdt_wake;

    // per-source flag and enable pairing
    for (genvar i = 0; i < IRQ_N; i++) begin : g_arm
        assign armed[i] = irq_flag[i] & irq_en[i];
    end

    assign irq_pend    = |armed;
    assign wdt_hit     = wdt_timeout & wdt_enable;
    assign ost_run     = (state == ST_START);
    assign vector_addr = ADDR_W'(VEC_ADDR);

    swc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .wdt_hit    (wdt_hit),
        .irq_pend   (irq_pend),
        .gie        (gie),
        .phase_last (phase_last),
        .ost_done   (ost_done),
        .state      (state),
        .osc_en     (osc_en),
        .core_halt  (core_halt),
        .resume     (resume_pulse),
        .vec        (vector_pulse),
        .wdt_clr    (wdt_clear),
        .sleep_exec (sleep_exec),
        .wdt_wake   (wdt_wake)
    );

    swc_phase #(.PHASES(PHASES)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (osc_en),
        .phase (cyc_phase),
        .last  (phase_last)
    );

    swc_ost #(.CYCLES(OST_CYCLES)) u_ost (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ost_run),
        .done  (ost_done)
    );

    swc_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_exec (sleep_exec),
        .wdt_wake   (wdt_wake),
        .pd         (status_pd),
        .to         (status_to)
    );

    // R7: release lands on the first phase
    p_release_phase1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> (cyc_phase == '0 && !core_halt));
    // R7: start-up window left only after the full count
    p_ost_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALIGN && $past(state) == ST_START) |-> $past(ost_done));
    // R9: vector pulse follows a full instruction cycle
    p_vec_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vector_pulse |-> ($past(cyc_phase) == PH_W'(PHASES - 1) && !core_halt));
    // R8: release and vector never coincide
    p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(resume_pulse && vector_pulse));
endmodule

// File: tb/sleep_wake_ctrl_tb.sv
module sleep_wake_ctrl_tb;
    localparam int OST   = 10;
    localparam int IRQ_N = 3;

    // table entry: [5] pending at strobe, [4:3] source (3 = watchdog),
    // [2] gie, [1] expected status_to, [0] expected vector
    localparam logic [5:0] CASES [8] = '{
        6'b0_00_0_1_0,
        6'b0_01_1_1_1,
        6'b0_10_0_1_0,
        6'b0_10_1_1_1,
        6'b0_11_0_0_0,
        6'b0_11_1_0_0,
        6'b1_00_0_1_0,
        6'b1_01_1_1_1
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n;
    logic             sleep_req, wdt_timeout, wdt_enable, gie;
    logic [IRQ_N-1:0] irq_flag, irq_en;
    logic             osc_en, core_halt, wdt_clear, resume_pulse, vector_pulse;
    logic [15:0]      vector_addr;
    logic [1:0]       cyc_phase;
    logic             status_to, status_pd;

    sleep_wake_ctrl #(.IRQ_N(IRQ_N), .OST_CYCLES(OST)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wdt_timeout(wdt_timeout),
        .wdt_enable(wdt_enable), .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie),
        .osc_en(osc_en), .core_halt(core_halt), .wdt_clear(wdt_clear),
        .resume_pulse(resume_pulse), .vector_pulse(vector_pulse),
        .vector_addr(vector_addr), .cyc_phase(cyc_phase),
        .status_to(status_to), .status_pd(status_pd)
    );

    int checks = 0;
    int failures = 0;
    int ph_m = 0;
    int ncyc = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: model the phase from osc_en seen before the edge
    task automatic cyc();
        logic o;
        o = osc_en;
        @(posedge clk);
        #1;
        ncyc++;
        if (o) ph_m = (ph_m + 1) % 4;
    endtask

    task automatic wait_resume();
        for (int i = 0; i < 3000 && !resume_pulse; i++) cyc();
    endtask

    task automatic run_case(input logic imm, input int src, input logic g,
                            input int exp_to, input int exp_vec);
        int q, a, bad;
        gie = g;
        wdt_enable = 1'b1;
        if (imm) begin
            irq_flag[src] = 1'b1;
            irq_en[src]   = 1'b1;
        end
        sleep_req = 1'b1;
        cyc();
        sleep_req = 1'b0;
        chk("R2 pd after strobe", status_pd, 0);
        chk("R2 to after strobe", status_to, 1);
        chk("R2 wdt_clear on strobe", wdt_clear, 1);
        chk("R3 halt on strobe", core_halt, 1);
        if (!imm) begin
            chk("R3 osc off", osc_en, 0);
            bad = 0;
            for (int i = 0; i < 3; i++) begin
                cyc();
                if (osc_en !== 1'b0 || core_halt !== 1'b1) bad++;
                if (i == 0) chk("R2 wdt_clear one cycle", wdt_clear, 0);
            end
            chk("R3 stays asleep", bad, 0);
            if (src == 3) wdt_timeout = 1'b1;
            else begin
                irq_flag[src] = 1'b1;
                irq_en[src]   = 1'b1;
            end
            q = (ph_m + OST) % 4;
            cyc();
            wdt_timeout = 1'b0;
            irq_flag = '0;
            irq_en   = '0;
            chk("R7 osc on after wake", osc_en, 1);
            chk("R7 halt after wake", core_halt, 1);
            chk("R6 wdt_clear on wake", wdt_clear, 1);
            chk((src == 3) ? "R5 to after watchdog wake" : "R4 to after irq wake",
                status_to, exp_to);
            a = ((3 - q) & 3) + 1;
            bad = 0;
            for (int i = 0; i < OST + a - 1; i++) begin
                cyc();
                if (core_halt !== 1'b1 || osc_en !== 1'b1 || resume_pulse !== 1'b0) bad++;
            end
            chk("R7 halted through start-up and alignment", bad, 0);
        end else begin
            chk("R10 osc stays on", osc_en, 1);
            irq_flag = '0;
            irq_en   = '0;
            q = ph_m;
            a = ((3 - q) & 3) + 1;
            bad = 0;
            for (int i = 0; i < a - 1; i++) begin
                cyc();
                if (core_halt !== 1'b1 || osc_en !== 1'b1) bad++;
            end
            chk("R10 halted until phase boundary", bad, 0);
        end
        cyc();
        chk("R8 resume pulse", resume_pulse, 1);
        chk("R8 halt released", core_halt, 0);
        chk("R7 release on phase 1 model", ph_m, 0);
        chk("R7 release phase port", cyc_phase, 0);
        for (int i = 1; i <= 4; i++) begin
            cyc();
            if (i < 4) chk("R9 no early vector", vector_pulse, 0);
            else begin
                chk("R9 vector pulse", vector_pulse, exp_vec);
                if (exp_vec != 0) chk("R9 vector address", vector_addr, 16'h0004);
            end
        end
        cyc();
        chk("R8 running again", core_halt, 0);
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", ncyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sleep_req = 1'b0; wdt_timeout = 1'b0; wdt_enable = 1'b0;
        gie = 1'b0; irq_flag = '0; irq_en = '0;
        #12;
        chk("R1 pd reset", status_pd, 1);
        chk("R1 to reset", status_to, 1);
        chk("R1 osc reset", osc_en, 1);
        chk("R1 halt reset", core_halt, 0);
        chk("R1 pulses reset", {wdt_clear, resume_pulse, vector_pulse}, 0);
        chk("R1 phase reset", cyc_phase, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        ph_m = 0;
        cyc();

        // R12: watchdog time-out while running
        wdt_enable = 1'b1; wdt_timeout = 1'b1;
        cyc();
        wdt_timeout = 1'b0;
        cyc();
        chk("R12 to unchanged", status_to, 1);
        chk("R12 pd unchanged", status_pd, 1);
        chk("R12 halt unchanged", core_halt, 0);

        // table of wake cases, with varying gaps to move the phase
        for (int k = 0; k < 8; k++) begin
            for (int g = 0; g < (k % 4); g++) cyc();
            run_case(CASES[k][5], int'(CASES[k][4:3]), CASES[k][2],
                     int'(CASES[k][1]), int'(CASES[k][0]));
        end

        // R3: ignored sources while asleep
        gie = 1'b1; wdt_enable = 1'b0;
        sleep_req = 1'b1; cyc(); sleep_req = 1'b0;
        irq_flag[0] = 1'b1;
        wdt_timeout = 1'b1;
        for (int i = 0; i < 4; i++) cyc();
        wdt_timeout = 1'b0;
        chk("R3 disabled sources ignored", osc_en, 0);
        chk("R3 to kept with watchdog disabled", status_to, 1);
        irq_en[0] = 1'b1;
        cyc();
        irq_flag = '0; irq_en = '0;
        chk("R4 wake with gie=1", osc_en, 1);
        wait_resume();
        chk("R4 released", resume_pulse, 1);
        for (int i = 0; i < 5; i++) cyc();

        // R5: watchdog and interrupt in the same cycle
        wdt_enable = 1'b1;
        sleep_req = 1'b1; cyc(); sleep_req = 1'b0;
        cyc();
        wdt_timeout = 1'b1; irq_flag[2] = 1'b1; irq_en[2] = 1'b1;
        cyc();
        wdt_timeout = 1'b0; irq_flag = '0; irq_en = '0;
        chk("R5 watchdog wins status", status_to, 0);
        wait_resume();
        begin
            int seen = 0;
            for (int i = 0; i < 6; i++) begin
                cyc();
                if (vector_pulse) seen++;
            end
            chk("R5 watchdog wake stays in line", seen, 0);
        end

        // R11: external reset during sleep
        sleep_req = 1'b1; cyc(); sleep_req = 1'b0;
        cyc();
        #1 rst_n = 1'b0;
        #1;
        chk("R11 osc after reset", osc_en, 1);
        chk("R11 halt after reset", core_halt, 0);
        chk("R11 pd after reset", status_pd, 1);
        chk("R11 to after reset", status_to, 1);
        @(posedge clk); #1;
        rst_n = 1'b1;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule